// File: doc/BRIEF.md
# Rotating Arbitration ID Tracker

This block holds the 4-bit arbitration ID for one agent on a shared interrupt-message bus. Bus priority on that bus rotates, and no central arbiter tracks it. Every agent watches each completed transaction and updates its own ID by the same rule. As a result, the set of IDs across all agents stays a permutation.

When a message completes without error, the block updates the ID:
- If this agent won, its ID drops to 0, which is the lowest priority.
- If another agent won and this agent holds 15, it takes the winner's old ID plus one.
- In every other case, the ID increments by one.

A failed message leaves the ID unchanged. The ID can also be reloaded in two ways:
- A write to the agent ID register loads the written value.
- An INIT-level-deassert message reloads the last written agent ID.

The ID is presented directly and also inside a 32-bit register read view.

Top module: `arb_id_tracker`

## Requirements
- R1: After reset, `arbId` is 0, `regView` is 0, and the stored agent ID is 0.
- R2: A successful transaction (`txnDone`=1, `csErr`=0, `accErr`=0) with `selfWon`=1 sets `arbId` to 0 at that clock edge.
- R3: A successful transaction with `selfWon`=0, while `arbId` is not 15, sets `arbId` to its previous value plus one.
- R4: A successful transaction with `selfWon`=0, while `arbId` is 15, sets `arbId` to `winnerId`+1 modulo 16 (winner 15 gives 0).
- R5: In any of the following cases, `arbId` keeps its value when no reload occurs:
  - a transaction that reports `csErr`;
  - a transaction that reports `accErr`;
  - any cycle without `txnDone`.
- R6: `idWrEn`=1 stores `idWrData` as the agent ID and loads it into `arbId` at the same edge.
- R7: `initDeassert`=1 loads `arbId` with the stored agent ID.
- R8: `regView` carries `arbId` in bits 27:24, and all its other bits read 0.
- R9: A reload (`idWrEn` or `initDeassert`) overrides a successful-transaction update in the same cycle. When `idWrEn` and `initDeassert` coincide, `arbId` takes the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnDone | input | 1 | One-cycle pulse at the end of a bus message |
| csErr | input | 1 | Checksum error reported for the message |
| accErr | input | 1 | Acceptance error reported for the message |
| selfWon | input | 1 | This agent won the message's arbitration |
| winnerId | input | 4 | Arbitration ID held by the winner before the update |
| idWrEn | input | 1 | Agent ID register write strobe |
| idWrData | input | 4 | New agent ID |
| initDeassert | input | 1 | INIT-level-deassert message received |
| arbId | output | 4 | Current arbitration ID |
| regView | output | 32 | Read view with the ID in bits 27:24 |

## Verification
Any wrong update shows at `arbId` and `regView[27:24]` on the first sampling after the edge that takes the strobe, because both are driven straight from one register. A rotation error persists until the next reload, so it also corrupts every later step. A missed hold on a failed message shifts the ID by one. A wrong wrap at 15 gives a value unrelated to the winner's ID. A lost agent ID shows only later, when an INIT-level deassert restores the wrong value.

// File: rtl/arb_id_pkg.sv
package arb_id_pkg;
  typedef struct packed {
    logic loadWr;
    logic loadInit;
    logic clearId;
    logic takeWinner;
    logic bumpId;
  } arbStrobes_t;
endpackage

// File: rtl/arb_id_ctrl.sv
module arb_id_ctrl
  import arb_id_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            txnDone,
  input  logic            csErr,
  input  logic            accErr,
  input  logic            selfWon,
  input  logic [ID_W-1:0] winnerId,
  input  logic            idWrEn,
  input  logic [ID_W-1:0] idWrData,
  input  logic            initDeassert,
  input  logic            atTop,
  input  logic [ID_W-1:0] arbIdQ,
  output arbStrobes_t     strobes
);
  localparam logic [ID_W-1:0] ID_MAX = {ID_W{1'b1}};

  logic txnGood;
  logic reload;

  always_comb begin
    txnGood = txnDone && !csErr && !accErr;
    reload  = idWrEn || initDeassert;
    strobes = '0;
    if (idWrEn)            strobes.loadWr     = 1'b1;
    else if (initDeassert) strobes.loadInit   = 1'b1;
    else if (txnGood) begin
      if (selfWon)         strobes.clearId    = 1'b1;
      else if (atTop)      strobes.takeWinner = 1'b1;
      else                 strobes.bumpId     = 1'b1;
    end
  end

  // R2: own win drops to lowest priority
  p_self_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txnGood && selfWon && !reload) |=> (arbIdQ == '0));

  // R3: ordinary agents step up by one
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txnGood && !selfWon && !reload && arbIdQ != ID_MAX)
      |=> (arbIdQ == ID_W'($past(arbIdQ) + 1'b1)));

  // R4: agent at the top inherits winner's ID plus one
  p_take_winner_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txnGood && !selfWon && !reload && arbIdQ == ID_MAX)
      |=> (arbIdQ == ID_W'($past(winnerId) + 1'b1)));

  // R5: failed or absent messages leave the ID alone
  p_fail_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!txnGood && !reload) |=> $stable(arbIdQ));

  // R6, R9: a write always wins
  p_write_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    idWrEn |=> (arbIdQ == $past(idWrData)));
endmodule

// File: rtl/arb_id_dp.sv
module arb_id_dp
  import arb_id_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int VIEW_W = 32,
  parameter int ID_LSB = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobes_t       strobes,
  input  logic [ID_W-1:0]   winnerId,
  input  logic [ID_W-1:0]   idWrData,
  output logic              atTop,
  output logic [ID_W-1:0]   arbIdQ,
  output logic [VIEW_W-1:0] regView
);
  localparam logic [ID_W-1:0] ID_MAX = {ID_W{1'b1}};

  logic [ID_W-1:0] agentIdQ;
  logic [ID_W-1:0] arbIdNext;

  always_ff @(posedge clk) begin
    if (!rstN)               agentIdQ <= '0;
    else if (strobes.loadWr) agentIdQ <= idWrData;
  end

  always_comb begin
    arbIdNext = arbIdQ;
    unique case (1'b1)
      strobes.loadWr:     arbIdNext = idWrData;
      strobes.loadInit:   arbIdNext = agentIdQ;
      strobes.clearId:    arbIdNext = '0;
      strobes.takeWinner: arbIdNext = winnerId + 1'b1;
      strobes.bumpId:     arbIdNext = arbIdQ + 1'b1;
      default:            arbIdNext = arbIdQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) arbIdQ <= '0;
    else       arbIdQ <= arbIdNext;
  end

  assign atTop = (arbIdQ == ID_MAX);

  always_comb begin
    regView = '0;
    regView[ID_LSB +: ID_W] = arbIdQ;
  end

  // R7: INIT deassert restores the stored agent ID
  p_init_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadInit |=> (arbIdQ == $past(agentIdQ)));

  // at most one strobe from control per cycle
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
endmodule

// File: rtl/arb_id_tracker.sv
module arb_id_tracker
  import arb_id_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int VIEW_W = 32,
  parameter int ID_LSB = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnDone,
  input  logic              csErr,
  input  logic              accErr,
  input  logic              selfWon,
  input  logic [ID_W-1:0]   winnerId,
  input  logic              idWrEn,
  input  logic [ID_W-1:0]   idWrData,
  input  logic              initDeassert,
  output logic [ID_W-1:0]   arbId,
  output logic [VIEW_W-1:0] regView
);
  arbStrobes_t strobes;
  logic        atTop;

  arb_id_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txnDone(txnDone), .csErr(csErr), .accErr(accErr),
    .selfWon(selfWon), .winnerId(winnerId), .idWrEn(idWrEn), .idWrData(idWrData),
    .initDeassert(initDeassert), .atTop(atTop), .arbIdQ(arbId), .strobes(strobes)
  );

  arb_id_dp #(.ID_W(ID_W), .VIEW_W(VIEW_W), .ID_LSB(ID_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .winnerId(winnerId),
    .idWrData(idWrData), .atTop(atTop), .arbIdQ(arbId), .regView(regView)
  );
endmodule

// File: tb/arb_id_tracker_tb.sv
module arb_id_tracker_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        txnDone, csErr, accErr, selfWon, idWrEn, initDeassert;
  logic [3:0]  winnerId, idWrData;
  logic [3:0]  arbId;
  logic [31:0] regView;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  arb_id_tracker u_dut (
    .clk(clk), .rstN(rstN), .txnDone(txnDone), .csErr(csErr), .accErr(accErr),
    .selfWon(selfWon), .winnerId(winnerId), .idWrEn(idWrEn), .idWrData(idWrData),
    .initDeassert(initDeassert), .arbId(arbId), .regView(regView)
  );

  // fields: [17]txn [16]cs [15]acc [14]self [13:10]winner [9]wr [8:5]wrData [4]init [3:0]expected
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {4'b0000, 4'd0,  1'b1, 4'd5,  1'b0, 4'd5},   // R6 write 5
    {4'b1000, 4'd3,  1'b0, 4'd0,  1'b0, 4'd6},   // R3
    {4'b1100, 4'd3,  1'b0, 4'd0,  1'b0, 4'd6},   // R5 cs
    {4'b1010, 4'd3,  1'b0, 4'd0,  1'b0, 4'd6},   // R5 acc
    {4'b1000, 4'd1,  1'b0, 4'd0,  1'b0, 4'd7},   // R3
    {4'b1001, 4'd7,  1'b0, 4'd0,  1'b0, 4'd0},   // R2
    {4'b0000, 4'd0,  1'b1, 4'd14, 1'b0, 4'd14},  // R6 write 14
    {4'b1000, 4'd2,  1'b0, 4'd0,  1'b0, 4'd15},  // R3 to top
    {4'b1000, 4'd9,  1'b0, 4'd0,  1'b0, 4'd10},  // R4
    {4'b0000, 4'd0,  1'b0, 4'd0,  1'b1, 4'd14},  // R7
    {4'b1000, 4'd4,  1'b0, 4'd0,  1'b1, 4'd14},  // R9 init over txn
    {4'b1001, 4'd0,  1'b1, 4'd3,  1'b0, 4'd3},   // R9 write over self win
    {4'b0000, 4'd0,  1'b1, 4'd9,  1'b1, 4'd9},   // R9 write with init
    {4'b0000, 4'd0,  1'b0, 4'd0,  1'b0, 4'd9},   // R5 idle
    {4'b1000, 4'd0,  1'b0, 4'd0,  1'b0, 4'd10},  // R3
    {4'b1111, 4'd2,  1'b0, 4'd0,  1'b0, 4'd10},  // R5 both errors
    {4'b1001, 4'd6,  1'b0, 4'd0,  1'b0, 4'd0}    // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    txnDone = 0; csErr = 0; accErr = 0; selfWon = 0; winnerId = 0;
    idWrEn = 0; idWrData = 0; initDeassert = 0;
  endtask

  task automatic apply(input logic [17:0] v, input string req);
    @(negedge clk);
    {txnDone, csErr, accErr, selfWon} = v[17:14];
    winnerId = v[13:10]; idWrEn = v[9]; idWrData = v[8:5]; initDeassert = v[4];
    @(posedge clk);
    #1;
    check(req, {28'd0, arbId}, {28'd0, v[3:0]});
    check("R8", regView, {4'd0, v[3:0], 24'd0});
    clearIn();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clearIn();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    check("R1", {28'd0, arbId}, 32'd0);
    check("R1", regView, 32'd0);

    for (int i = 0; i < NV; i++) apply(VEC[i], "R2-vector");

    // R4 wrap: at 15, winner 15 -> 0
    apply({4'b0000, 4'd0, 1'b1, 4'd15, 1'b0, 4'd15}, "R6");
    apply({4'b1000, 4'd15, 1'b0, 4'd0, 1'b0, 4'd0}, "R4");

    // R1: reset clears the stored agent ID as well
    apply({4'b0000, 4'd0, 1'b1, 4'd7, 1'b0, 4'd7}, "R6");
    @(negedge clk); rstN = 0;
    @(posedge clk); #1;
    check("R1", {28'd0, arbId}, 32'd0);
    @(negedge clk); rstN = 1;
    apply({4'b0000, 4'd0, 1'b0, 4'd0, 1'b1, 4'd0}, "R1");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule